// File: doc/BRIEF.md
# Multiplexed External Memory Read Sequencer

This block runs one read of an external asynchronous data memory over a time-shared bus, and counts every interval in whole periods of its core clock (tCK). An internal requester raises `req` with a 24-bit byte address. The block then raises `ale` and puts the low address byte on the bidirectional low port and the top address byte on the output-only high port. A transparent latch outside the block holds both bytes when `ale` falls. For the rest of the cycle the high port shows the middle address byte. After a short hold the low port lets go of the bus. `rd_n` is then pulsed low, and the memory answers on the low port.

The returned byte is taken at the clock edge where `rd_n` returns high. It appears on `rd_data`, and `done` is high for one cycle at the same time. After a recovery gap the block goes back to idle. A `req` that arrives while a cycle is running is not queued: it is dropped. `psen_n` belongs to the program-fetch path and is held inactive. The low port is split into `ad_out`, `ad_oe` and `ad_in`, and the pad ring builds the tri-state buffer from them.

Top module: `xmem_rd_seq`

## Requirements
- R1: While `rst_n` is low and after it is released with `req` low, `ale`=0, `rd_n`=1, `psen_n`=1, `ad_oe`=0 and `done`=0.
- R2: A `req` sampled high in idle makes `ale` high for exactly 2 tCK, starting in the next cycle. During that time `ad_oe`=1, `ad_out` = address bits 7:0 and `hi_addr` = address bits 23:16.
- R3: `ad_oe` stays 1 with the low address byte for exactly 1 tCK after `ale` falls, then drops to 0.
- R4: `rd_n` falls exactly 3 tCK after `ale` falls, and `ad_oe` is 0 in every cycle in which `rd_n` is 0.
- R5: `rd_n` stays low for exactly 6 tCK.
- R6: From the fall of `ale` until the cycle ends, `hi_addr` = address bits 15:8.
- R7: `rd_data` takes the `ad_in` value present at the clock edge where `rd_n` rises. `done` is high for exactly the one cycle that follows that edge.
- R8: `ale` rises again no sooner than 3 tCK after `rd_n` rises, and exactly 3 tCK after when `req` is held high.
- R9: `psen_n` is 1 in every cycle.
- R10: A `req` raised while a cycle is in progress is ignored. It starts no new cycle and does not change the address of the running one.
- R11: With `req` held high, a new cycle starts on the first idle cycle and uses the `req_addr` present at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one period is one tCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start request, taken only when idle |
| req_addr | input | 24 | Byte address for the read |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| psen_n | output | 1 | Program-fetch strobe, held inactive |
| ad_out | output | 8 | Low port output value (address bits 7:0) |
| ad_oe | output | 1 | Low port output enable |
| ad_in | input | 8 | Low port input value (data from memory) |
| hi_addr | output | 8 | High port: bits 23:16 while `ale` is high, bits 15:8 otherwise |
| done | output | 1 | One-cycle pulse when `rd_data` is fresh |
| rd_data | output | 8 | Byte captured at the rise of `rd_n` |

## Verification
Some rules are checked by the bound checker on every clock edge:
- the count of tCK from the fall of `ale` to the fall of `rd_n`;
- the width of the `rd_n` pulse;
- the gap from the rise of `rd_n` to the next rise of `ale`;
- the one extra tCK of address drive after `ale` falls;
- the rule that the low port never drives while `rd_n` is low;
- `done` coinciding with the rise of `rd_n`, and `psen_n` staying high.

The bench's scenarios are needed for the rest:
- the address byte order on both ports;
- the returned byte, checked against a latch model and a memory model that shows valid data only in the last tCK of the strobe;
- dropping a request raised mid-cycle;
- the start of back-to-back reads.

// File: rtl/xmem_rd_pkg.sv
package xmem_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_HOLD,
    ST_STROBE,
    ST_RECOVER
  } rd_state_e;

  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // Number of tCK a state lasts before the sequence moves on.
  function automatic int unsigned state_dwell(input rd_state_e s,
                                              input int unsigned addr_t,
                                              input int unsigned delay_t,
                                              input int unsigned strobe_t,
                                              input int unsigned recover_t);
    case (s)
      ST_ADDR:    return addr_t;
      ST_HOLD:    return delay_t;
      ST_STROBE:  return strobe_t;
      ST_RECOVER: return recover_t;
      default:    return 1;
    endcase
  endfunction

  // Fixed order of the read sequence.
  function automatic rd_state_e state_after(input rd_state_e s);
    case (s)
      ST_IDLE:   return ST_ADDR;
      ST_ADDR:   return ST_HOLD;
      ST_HOLD:   return ST_STROBE;
      ST_STROBE: return ST_RECOVER;
      default:   return ST_IDLE;
    endcase
  endfunction

  // The low port drives the address while ALE is high and for hold_t tCK after.
  function automatic logic lo_addr_drive(input rd_state_e s, input int unsigned elapsed,
                                         input int unsigned hold_t);
    case (s)
      ST_ADDR: return 1'b1;
      ST_HOLD: return elapsed < hold_t;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/xmem_rd_tick.sv
module xmem_rd_tick #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] elapsed,
  output logic             last
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed <= '0;
    end else if (restart) begin
      elapsed <= '0;
    end else if (elapsed != CNT_TOP) begin
      elapsed <= elapsed + CNT_W'(1);
    end
  end

  assign last = (elapsed == limit - CNT_W'(1));

endmodule

// File: rtl/xmem_rd_ctl.sv
module xmem_rd_ctl
  import xmem_rd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req,
  input  logic      seg_last,
  output rd_state_e state,
  output logic      restart
);

  rd_state_e state_nx;

  always_comb begin
    state_nx = state;
    restart  = 1'b0;
    if (state == ST_IDLE) begin
      if (req) begin
        state_nx = ST_ADDR;
        restart  = 1'b1;
      end
    end else if (seg_last) begin
      state_nx = state_after(state);
      restart  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

endmodule

// File: rtl/xmem_rd_bus.sv
module xmem_rd_bus
  import xmem_rd_pkg::*;
#(
  parameter int          BYTE_W        = 8,
  parameter int          CNT_W         = 4,
  parameter int unsigned ADDR_HOLD_TCK = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic                capture,
  input  logic [3*BYTE_W-1:0] req_addr,
  input  rd_state_e           state,
  input  logic [CNT_W-1:0]    elapsed,
  input  logic [BYTE_W-1:0]   ad_in,
  output logic                ale,
  output logic                rd_n,
  output logic                psen_n,
  output logic [BYTE_W-1:0]   ad_out,
  output logic                ad_oe,
  output logic [BYTE_W-1:0]   hi_addr,
  output logic                done,
  output logic [BYTE_W-1:0]   rd_data
);

  logic [3*BYTE_W-1:0] addr_q;
  logic [BYTE_W-1:0]   lo_byte, mid_byte, top_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (accept) addr_q <= req_addr;
  end

  assign lo_byte  = addr_q[BYTE_W-1:0];
  assign mid_byte = addr_q[2*BYTE_W-1:BYTE_W];
  assign top_byte = addr_q[3*BYTE_W-1:2*BYTE_W];

  assign ale     = (state == ST_ADDR);
  assign rd_n    = (state != ST_STROBE);
  assign psen_n  = 1'b1;
  assign ad_oe   = lo_addr_drive(state, 32'(elapsed), ADDR_HOLD_TCK);
  assign ad_out  = ad_oe ? lo_byte : '0;
  assign hi_addr = ale ? top_byte : mid_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= capture;
      if (capture) rd_data <= ad_in;
    end
  end

endmodule

// File: rtl/xmem_rd_seq.sv
module xmem_rd_seq
  import xmem_rd_pkg::*;
#(
  parameter int          BYTE_W        = 8,
  parameter int unsigned ADDR_TCK      = 2,
  parameter int unsigned ADDR_HOLD_TCK = 1,
  parameter int unsigned RD_DELAY_TCK  = 3,
  parameter int unsigned RD_WIDTH_TCK  = 6,
  parameter int unsigned RECOVER_TCK   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req,
  input  logic [3*BYTE_W-1:0] req_addr,
  output logic                ale,
  output logic                rd_n,
  output logic                psen_n,
  output logic [BYTE_W-1:0]   ad_out,
  output logic                ad_oe,
  input  logic [BYTE_W-1:0]   ad_in,
  output logic [BYTE_W-1:0]   hi_addr,
  output logic                done,
  output logic [BYTE_W-1:0]   rd_data
);

  localparam int unsigned SPAN  = max_of4(ADDR_TCK, RD_DELAY_TCK, RD_WIDTH_TCK, RECOVER_TCK);
  localparam int          CNT_W = $clog2(SPAN + 1) + 1;

  rd_state_e        state;
  logic             seg_restart;
  logic             seg_last;
  logic [CNT_W-1:0] seg_limit;
  logic [CNT_W-1:0] seg_elapsed;

  // Named events, shared by the datapath and the checker.
  logic ev_accept;
  logic ev_rd_rise;

  assign seg_limit  = CNT_W'(state_dwell(state, ADDR_TCK, RD_DELAY_TCK, RD_WIDTH_TCK, RECOVER_TCK));
  assign ev_accept  = (state == ST_IDLE) && req;
  assign ev_rd_rise = (state == ST_STROBE) && seg_last;

  xmem_rd_tick #(.CNT_W(CNT_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (seg_restart),
    .limit   (seg_limit),
    .elapsed (seg_elapsed),
    .last    (seg_last)
  );

  xmem_rd_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .seg_last (seg_last),
    .state    (state),
    .restart  (seg_restart)
  );

  xmem_rd_bus #(
    .BYTE_W        (BYTE_W),
    .CNT_W         (CNT_W),
    .ADDR_HOLD_TCK (ADDR_HOLD_TCK)
  ) u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (ev_accept),
    .capture  (ev_rd_rise),
    .req_addr (req_addr),
    .state    (state),
    .elapsed  (seg_elapsed),
    .ad_in    (ad_in),
    .ale      (ale),
    .rd_n     (rd_n),
    .psen_n   (psen_n),
    .ad_out   (ad_out),
    .ad_oe    (ad_oe),
    .hi_addr  (hi_addr),
    .done     (done),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/xmem_rd_chk.sv
module xmem_rd_chk #(
  parameter int unsigned RD_DELAY_TCK = 3,
  parameter int unsigned RD_WIDTH_TCK = 6,
  parameter int unsigned RECOVER_TCK  = 2
) (
  input logic clk,
  input logic rst_n,
  input logic ale,
  input logic rd_n,
  input logic psen_n,
  input logic ad_oe,
  input logic done,
  input logic ev_accept
);

  localparam int CW = $clog2(RD_DELAY_TCK + RD_WIDTH_TCK + RECOVER_TCK + 4) + 1;
  localparam logic [CW-1:0] CTOP = {CW{1'b1}};

  logic          ale_d, rd_d;
  logic [CW-1:0] since_ale_fall, low_run, since_rd_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_d          <= 1'b0;
      rd_d           <= 1'b1;
      since_ale_fall <= CTOP;
      low_run        <= '0;
      since_rd_rise  <= CTOP;
    end else begin
      ale_d <= ale;
      rd_d  <= rd_n;
      if (ale_d && !ale)              since_ale_fall <= CW'(1);
      else if (since_ale_fall != CTOP) since_ale_fall <= since_ale_fall + CW'(1);
      if (!rd_n)                      low_run <= (low_run != CTOP) ? low_run + CW'(1) : low_run;
      else                            low_run <= '0;
      if (!rd_d && rd_n)              since_rd_rise <= CW'(1);
      else if (since_rd_rise != CTOP) since_rd_rise <= since_rd_rise + CW'(1);
    end
  end

  a_r9_psen_inactive: assert property (@(posedge clk) disable iff (!rst_n) psen_n);

  a_r4_float_in_strobe: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !ad_oe);

  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n) $fell(ale) |-> ad_oe);

  a_r4_rd_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> (since_ale_fall == CW'(RD_DELAY_TCK)));

  a_r5_rd_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> (low_run == CW'(RD_WIDTH_TCK)));

  a_r8_ale_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |-> (since_rd_rise >= CW'(RECOVER_TCK + 1)));

  a_r7_done_at_rd_rise: assert property (@(posedge clk) disable iff (!rst_n) $rose(rd_n) |-> done);

  a_r7_done_only_at_rd_rise: assert property (@(posedge clk) disable iff (!rst_n) done |-> $rose(rd_n));

  a_r10_start_from_accept: assert property (@(posedge clk) disable iff (!rst_n) $rose(ale) |-> $past(ev_accept));

endmodule

bind xmem_rd_seq xmem_rd_chk #(
  .RD_DELAY_TCK (RD_DELAY_TCK),
  .RD_WIDTH_TCK (RD_WIDTH_TCK),
  .RECOVER_TCK  (RECOVER_TCK)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ale       (ale),
  .rd_n      (rd_n),
  .psen_n    (psen_n),
  .ad_oe     (ad_oe),
  .done      (done),
  .ev_accept (ev_accept)
);

// File: tb/xmem_rd_seq_test.sv
module xmem_rd_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int ALE_W  = 2;   // R2
  localparam int HOLD_W = 1;   // R3
  localparam int DLY_W  = 3;   // R4
  localparam int LOW_W  = 6;   // R5
  localparam int GAP_W  = 3;   // R8
  localparam int NS     = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [23:0] req_addr = '0;
  logic [7:0]  ad_in = '0;
  logic        ale, rd_n, psen_n, ad_oe, done;
  logic [7:0]  ad_out, hi_addr, rd_data;

  int total = 0;
  int bad = 0;
  int psen_bad = 0;
  int clash_bad = 0;

  logic       s_ale [NS];
  logic       s_rd  [NS];
  logic       s_oe  [NS];
  logic       s_done[NS];
  logic [7:0] s_lo  [NS];
  logic [7:0] s_hi  [NS];
  logic [7:0] s_data[NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  xmem_rd_seq uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
    .ale(ale), .rd_n(rd_n), .psen_n(psen_n), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in), .hi_addr(hi_addr), .done(done), .rd_data(rd_data)
  );

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return {a[3:0], a[7:4]} ^ a[15:8] ^ (a[23:16] + 8'h3C);
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int find(input int which, input int from, input logic v);
    if (from < 0) return -1;
    for (int i = from; i < NS; i++) begin
      logic x;
      case (which)
        0:       x = s_ale[i];
        1:       x = s_rd[i];
        2:       x = s_oe[i];
        default: x = s_done[i];
      endcase
      if (x === v) return i;
    end
    return -1;
  endfunction

  // Samples at each falling edge and plays the latch and memory models.
  task automatic observe(input int n, input int req_until, input int pulse_at,
                         input logic [23:0] pulse_addr, input int sw_at,
                         input logic [23:0] sw_addr);
    int lowk;
    logic [7:0] l_lo, l_hi;
    lowk = 0; l_lo = '0; l_hi = '0;
    for (int i = 0; i < NS; i++) begin
      s_ale[i] = 1'bx; s_rd[i] = 1'bx; s_oe[i] = 1'bx; s_done[i] = 1'bx;
      s_lo[i] = 'x; s_hi[i] = 'x; s_data[i] = 'x;
    end
    for (int s = 0; s < n; s++) begin
      @(negedge clk);
      s_ale[s] = ale; s_rd[s] = rd_n; s_oe[s] = ad_oe; s_done[s] = done;
      s_lo[s] = ad_out; s_hi[s] = hi_addr; s_data[s] = rd_data;
      if (psen_n !== 1'b1) psen_bad++;
      if (rd_n === 1'b0 && ad_oe !== 1'b0) clash_bad++;
      if (ale === 1'b1) begin l_lo = ad_out; l_hi = hi_addr; end
      if (rd_n === 1'b0) begin
        lowk++;
        ad_in = (lowk >= LOW_W) ? mem_byte({l_hi, hi_addr, l_lo}) : (8'hA5 ^ lowk[7:0]);
      end else begin
        lowk = 0;
        ad_in = 8'h5A;
      end
      if (s == sw_at) req_addr = sw_addr;
      if (s == pulse_at) begin
        req = 1'b1;
        req_addr = pulse_addr;
      end else begin
        req = (s < req_until);
      end
    end
  endtask

  task automatic check_read(input int b, input logic [23:0] a);
    int ar, af, ofl, rf, rr, dn;
    ar = find(0, b, 1'b1);
    af = find(0, ar, 1'b0);
    ofl = find(2, af, 1'b0);
    rf = find(1, af, 1'b0);
    rr = find(1, rf, 1'b1);
    dn = find(3, b, 1'b1);
    chk(ar == b, "R2 ale rise sample", ar, b);
    if (ar < 0 || rr < 0 || dn < 0) begin
      chk(1'b0, "R2 cycle incomplete", rr, 0);
      return;
    end
    chk(af - ar == ALE_W, "R2 ale high width", af - ar, ALE_W);
    chk(s_oe[ar] === 1'b1 && s_lo[ar] === a[7:0], "R2 low port address", s_lo[ar], a[7:0]);
    chk(s_hi[ar] === a[23:16], "R2 high port top byte", s_hi[ar], a[23:16]);
    chk(ofl - af == HOLD_W, "R3 address hold after ale fall", ofl - af, HOLD_W);
    chk(rf - af == DLY_W, "R4 ale fall to rd fall", rf - af, DLY_W);
    chk(rr - rf == LOW_W, "R5 rd low width", rr - rf, LOW_W);
    chk(s_hi[af] === a[15:8] && s_hi[rf] === a[15:8] && s_hi[rr] === a[15:8],
        "R6 high port middle byte", s_hi[rf], a[15:8]);
    chk(dn == rr, "R7 done at rd rise", dn, rr);
    chk(s_done[dn+1] === 1'b0, "R7 done one cycle", s_done[dn+1], 0);
    chk(s_data[dn] === mem_byte(a), "R7 captured byte", s_data[dn], mem_byte(a));
  endtask

  task automatic start(input logic [23:0] a);
    @(negedge clk);
    req = 1'b1;
    req_addr = a;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(ale === 1'b0 && rd_n === 1'b1 && psen_n === 1'b1 && ad_oe === 1'b0 && done === 1'b0,
        "R1 outputs in reset", {ale, rd_n, psen_n, ad_oe, done}, 5'b01100);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ale === 1'b0 && rd_n === 1'b1 && psen_n === 1'b1 && ad_oe === 1'b0 && done === 1'b0,
        "R1 outputs idle after reset", {ale, rd_n, psen_n, ad_oe, done}, 5'b01100);
  endtask

  task automatic t_single(input logic [23:0] a);
    int pb, cb;
    pb = psen_bad; cb = clash_bad;
    start(a);
    observe(20, 0, -1, '0, -1, '0);
    check_read(0, a);
    chk(psen_bad == pb, "R9 psen_n stays high", psen_bad - pb, 0);
    chk(clash_bad == cb, "R4 low port released while rd low", clash_bad - cb, 0);
  endtask

  task automatic t_ignore_busy(input logic [23:0] a, input logic [23:0] other);
    start(a);
    observe(24, 0, 3, other, -1, '0);
    check_read(0, a);
    chk(find(0, 2, 1'b1) == -1, "R10 mid-cycle req ignored", find(0, 2, 1'b1), -1);
  endtask

  task automatic t_back_to_back(input logic [23:0] a, input logic [23:0] b);
    int rr1, ar2;
    start(a);
    observe(30, 30, -1, '0, 12, b);
    @(negedge clk);
    req = 1'b0;
    check_read(0, a);
    rr1 = find(1, find(1, 0, 1'b0), 1'b1);
    ar2 = find(0, 2, 1'b1);
    chk(ar2 - rr1 == GAP_W, "R8 rd rise to next ale rise", ar2 - rr1, GAP_W);
    chk(ar2 == 14, "R11 held req restarts at first idle", ar2, 14);
    check_read(14, b);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_single(24'h12_34_56);
    t_single(24'hFF_00_FF);
    t_single(24'h00_FF_00);
    t_single(24'hA5_C3_0F);
    t_ignore_busy(24'h3C_5A_96, 24'hC3_A5_69);
    t_single(24'h01_02_03);
    t_back_to_back(24'h7E_81_42, 24'h18_E7_BD);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule